// File: doc/BRIEF.md
# DRAM Refresh and Power-Up Sequencer

This block keeps a dynamic memory alive. After reset it holds the strobe lines idle for a power-up pause, then runs a burst of CAS-before-RAS refresh cycles on its own. When the last cycle of that burst has finished its precharge, it raises `init_done`. From then on an interval timer produces one refresh demand per average row period. The default period is 64 ms divided by 4096 rows, about 15.6 µs.

Demands are held in a saturating pending counter. While the counter is non-zero the block raises `ref_req` toward the access arbiter. A grant starts one refresh cycle. While the cycle runs, `bus_own` is high and the block drives RAS, CAS and WE. The cycle always runs to its end. No address is produced, because the memory takes the row from its internal counter.

All timing is counted in clock cycles. The CAS lead, the RAS low width and the precharge are derived from the clock period parameter. The pause length and the refresh interval are parameters as well.

Top module: `dram_refresh_seq`

## Requirements
- R1: After reset release, `ras_n` and `cas_n` stay high and `init_done` stays low for at least PAUSE_CYC cycles.
- R2: After the pause, INIT_N (default 8) refresh cycles run back to back without any grant. `ref_req` is never high while `init_done` is low.
- R3: `init_done` rises only after the last initialisation cycle has completed at least T_RP cycles of precharge with RAS high. Once high, it stays high until reset.
- R4: In every refresh cycle `cas_n` is low for exactly T_CSR cycles (1 at 5 ns) before `ras_n` falls, and it stays low for the whole time `ras_n` is low.
- R5: `ras_n` is low for exactly T_RAS cycles (12 at 5 ns). Successive RAS falling edges are at least T_RC cycles apart (21 at 5 ns, so at least 9 cycles of precharge).
- R6: While `bus_own` is high, `we_n` is high. While `bus_own` is low, `ras_n` and `cas_n` are both high.
- R7: After `init_done`, one refresh demand is added every REF_INTERVAL cycles. With the grant held high, successive CAS falling edges are exactly REF_INTERVAL cycles apart.
- R8: `ref_req` stays high while a demand is pending and no grant arrives. A grant while `ref_req` is low starts nothing. A grant while `ref_req` is high makes `cas_n` fall on the next cycle.
- R9: Once started, a refresh cycle completes with full RAS width even if the grant is removed after one cycle.
- R10: `pend_cnt` counts ungranted demands and saturates at PEND_MAX (8). A demand that arrives while it is full sets `pend_ovf`, which stays set until reset.
- R11: Each started refresh lowers `pend_cnt` by one. With the grant high, a full backlog drains to zero through consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref_gnt | input | 1 | Grant from the access arbiter |
| ref_req | output | 1 | Refresh request to the arbiter |
| bus_own | output | 1 | High while the block drives the memory strobes |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, held high |
| init_done | output | 1 | Power-up sequence complete |
| pend_cnt | output | $clog2(PEND_MAX+1) | Pending refresh demands |
| pend_ovf | output | 1 | Sticky pending-overflow flag |

## Verification
A wrong phase counter changes the width of a RAS or CAS pulse. That shows at the pins within one refresh cycle, about 22 clocks. A wrong state encoding puts RAS low without CAS low first, and the checker flags it on that same edge. A drifting interval timer or a miscounted pending counter only shows over several intervals, as altered spacing between CAS falls or a late overflow flag. The bench therefore measures edge-to-edge distances over several intervals rather than sampling single cycles.

// File: rtl/dram_refresh_seq.sv
module dram_refresh_seq #(
  parameter int CLK_NS       = 5,
  parameter int PAUSE_CYC    = (200000 + CLK_NS - 1) / CLK_NS,
  parameter int REF_INTERVAL = (64000000 / 4096) / CLK_NS,
  parameter int INIT_N       = 8,
  parameter int PEND_MAX     = 8,
  localparam int PW          = $clog2(PEND_MAX + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ref_gnt,
  output logic          ref_req,
  output logic          bus_own,
  output logic          ras_n,
  output logic          cas_n,
  output logic          we_n,
  output logic          init_done,
  output logic [PW-1:0] pend_cnt,
  output logic          pend_ovf
);
  localparam int CSR_CYC = (5 + CLK_NS - 1) / CLK_NS;
  localparam int RAS_CYC = (60 + CLK_NS - 1) / CLK_NS;
  localparam int RC_CYC  = (104 + CLK_NS - 1) / CLK_NS;
  localparam int RPM_CYC = (40 + CLK_NS - 1) / CLK_NS;
  localparam int RP_CYC  = (RC_CYC - RAS_CYC > RPM_CYC) ? RC_CYC - RAS_CYC : RPM_CYC;
  localparam int PH_MAX  = (RAS_CYC > RP_CYC) ? RAS_CYC : RP_CYC;
  localparam int PHW     = $clog2(PH_MAX + 1);
  localparam int TMAX    = (PAUSE_CYC > REF_INTERVAL) ? PAUSE_CYC : REF_INTERVAL;
  localparam int TW      = $clog2(TMAX + 1);
  localparam int IW      = $clog2(INIT_N + 1);

  typedef enum logic [2:0] {S_PAUSE, S_IDLE, S_CAS, S_RAS, S_PRE} st_t;

  st_t            st;
  logic [PHW-1:0] ph;
  logic [TW-1:0]  tmr;
  logic [IW-1:0]  icnt;
  logic           tick, start;

  assign tick    = init_done && (tmr == TW'(REF_INTERVAL - 1));
  assign ref_req = (st == S_IDLE) && (pend_cnt != '0);
  assign start   = ref_req && ref_gnt;
  assign bus_own = (st == S_CAS) || (st == S_RAS) || (st == S_PRE);
  assign cas_n   = !((st == S_CAS) || (st == S_RAS));
  assign ras_n   = (st != S_RAS);
  assign we_n    = 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmr <= '0;
    end else if (st == S_PAUSE) begin
      tmr <= (tmr == TW'(PAUSE_CYC - 1)) ? '0 : tmr + 1'b1;
    end else if (init_done) begin
      tmr <= tick ? '0 : tmr + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_cnt <= '0;
      pend_ovf <= 1'b0;
    end else if (tick && !start) begin
      if (pend_cnt == PW'(PEND_MAX)) pend_ovf <= 1'b1;
      else pend_cnt <= pend_cnt + 1'b1;
    end else if (!tick && start) begin
      pend_cnt <= pend_cnt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_PAUSE;
      ph        <= '0;
      icnt      <= '0;
      init_done <= 1'b0;
    end else begin
      case (st)
        S_PAUSE: if (tmr == TW'(PAUSE_CYC - 1)) begin
          st <= S_CAS;
          ph <= PHW'(CSR_CYC - 1);
        end
        S_IDLE: if (start) begin
          st <= S_CAS;
          ph <= PHW'(CSR_CYC - 1);
        end
        S_CAS: if (ph == '0) begin
          st <= S_RAS;
          ph <= PHW'(RAS_CYC - 1);
        end else ph <= ph - 1'b1;
        S_RAS: if (ph == '0) begin
          st <= S_PRE;
          ph <= PHW'(RP_CYC - 1);
        end else ph <= ph - 1'b1;
        S_PRE: if (ph != '0) begin
          ph <= ph - 1'b1;
        end else if (init_done) begin
          st <= S_IDLE;
        end else if (icnt == IW'(INIT_N - 1)) begin
          init_done <= 1'b1;
          st        <= S_IDLE;
        end else begin
          icnt <= icnt + 1'b1;
          st   <= S_CAS;
          ph   <= PHW'(CSR_CYC - 1);
        end
        default: st <= S_PAUSE;
      endcase
    end
  end
endmodule

// File: rtl/dram_refresh_seq_chk.sv
module dram_refresh_seq_chk #(
  parameter int PEND_MAX = 8,
  localparam int PW = $clog2(PEND_MAX + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ref_gnt,
  input logic          ref_req,
  input logic          bus_own,
  input logic          ras_n,
  input logic          cas_n,
  input logic          we_n,
  input logic          init_done,
  input logic [PW-1:0] pend_cnt,
  input logic          pend_ovf
);
  AST_CAS_BEFORE_RAS: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> $past(!cas_n)) else $error("cas lead"); // R4
  AST_CAS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !ras_n |-> !cas_n) else $error("cas held"); // R4
  AST_WE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    bus_own |-> we_n) else $error("we high"); // R6
  AST_IDLE_STROBES: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_own |-> (ras_n && cas_n)) else $error("idle strobes"); // R6
  AST_NO_EARLY_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    !init_done |-> !ref_req) else $error("early req"); // R2
  AST_INIT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |=> init_done) else $error("init sticky"); // R3
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_req && !ref_gnt) |=> ref_req) else $error("req hold"); // R8
  AST_GNT_START: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_req && ref_gnt) |=> !cas_n) else $error("grant start"); // R8
  AST_PEND_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    pend_cnt <= PW'(PEND_MAX)) else $error("pend bound"); // R10
  AST_NO_OVERFLOW_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    pend_ovf |=> pend_ovf) else $error("ovf sticky"); // R10
endmodule

bind dram_refresh_seq dram_refresh_seq_chk #(.PEND_MAX(PEND_MAX)) u_chk (
  .clk(clk), .rst_n(rst_n), .ref_gnt(ref_gnt), .ref_req(ref_req),
  .bus_own(bus_own), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
  .init_done(init_done), .pend_cnt(pend_cnt), .pend_ovf(pend_ovf)
);

// File: tb/dram_refresh_seq_bench.sv
module dram_refresh_seq_bench;
  localparam int PAUSE = 50;
  localparam int INTV  = 40;
  localparam int NINIT = 8;
  localparam int PMAX  = 8;
  localparam int T_CSR = 1;
  localparam int T_RAS = 12;
  localparam int T_RP  = 9;
  localparam int T_RC  = 21;

  logic clk = 1'b0, rst_n = 1'b0, ref_gnt = 1'b0;
  logic ref_req, bus_own, ras_n, cas_n, we_n, init_done, pend_ovf;
  logic [3:0] pend_cnt;
  int n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  dram_refresh_seq #(.PAUSE_CYC(PAUSE), .REF_INTERVAL(INTV), .INIT_N(NINIT), .PEND_MAX(PMAX))
  u_dram_refresh_seq (
    .clk(clk), .rst_n(rst_n), .ref_gnt(ref_gnt), .ref_req(ref_req), .bus_own(bus_own),
    .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .init_done(init_done),
    .pend_cnt(pend_cnt), .pend_ovf(pend_ovf));

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", rq, act, exp, $time);
    end
  endtask

  int cyc, cas_run, ras_run, n_ras, n_casf, last_casf, prev_casf, first_casf;
  int last_rasf, last_rise, last_len;
  bit cas_up, p_ras, p_cas;

  always @(negedge clk) begin
    if (!rst_n) begin
      cyc = 0; cas_run = 0; ras_run = 0; n_ras = 0; n_casf = 0;
      last_casf = -1; prev_casf = -1; first_casf = -1; last_rasf = -1;
      last_rise = -1; last_len = 0; cas_up = 0; p_ras = 1; p_cas = 1;
    end else begin
      cyc++;
      if (bus_own) chk(we_n == 1'b1, "R6 we_n", we_n, 1);
      else chk(ras_n && cas_n, "R6 idle strobes", {ras_n, cas_n}, 3);
      if (!init_done) chk(!ref_req, "R2 req before init", ref_req, 0);
      if (p_cas && !cas_n) begin
        n_casf++; prev_casf = last_casf; last_casf = cyc;
        if (first_casf < 0) first_casf = cyc;
      end
      if (p_ras && !ras_n) begin
        chk(!cas_n && cas_run == T_CSR, "R4 cas lead", cas_run, T_CSR);
        if (last_rasf >= 0) chk(cyc - last_rasf >= T_RC, "R5 ras period", cyc - last_rasf, T_RC);
        last_rasf = cyc; ras_run = 0; cas_up = 0;
      end
      if (!p_ras && ras_n) begin
        n_ras++; last_len = ras_run; last_rise = cyc;
        chk(ras_run == T_RAS, "R5 ras width", ras_run, T_RAS);
        chk(!cas_up, "R4 cas held", cas_up, 0);
      end
      if (!ras_n) ras_run++;
      if (!cas_n) cas_run++; else cas_run = 0;
      if (!ras_n && cas_n) cas_up = 1;
      p_ras = ras_n; p_cas = cas_n;
    end
  end

  task automatic smp(); @(negedge clk); #1; endtask
  task automatic drv(); @(posedge clk); #1; endtask

  task automatic do_reset();
    drv(); rst_n = 1'b0; ref_gnt = 1'b0;
    repeat (3) smp();
    chk(ras_n && cas_n && we_n, "R1 reset strobes", {ras_n, cas_n, we_n}, 7);
    chk(!ref_req && !bus_own, "R2 reset req", {ref_req, bus_own}, 0);
    chk(!init_done && !pend_ovf && pend_cnt == 0, "R10 reset state", pend_cnt, 0);
    drv(); rst_n = 1'b1;
  endtask

  task automatic wait_init();
    int w = 0;
    while (!init_done && w < 2000) begin smp(); w++; end
  endtask

  task automatic t_init();
    do_reset();
    wait_init();
    chk(init_done, "R3 init done seen", init_done, 1);
    chk(first_casf >= PAUSE, "R1 pause length", first_casf, PAUSE);
    chk(n_ras == NINIT, "R2 init burst count", n_ras, NINIT);
    chk(ras_n && cyc - last_rise >= T_RP, "R3 precharge before done", cyc - last_rise, T_RP);
    repeat (5) smp();
    chk(init_done, "R3 sticky", init_done, 1);
  endtask

  task automatic t_no_req_gnt();
    int n0;
    do_reset(); wait_init();
    n0 = n_casf;
    drv(); ref_gnt = 1'b1;
    repeat (20) smp();
    chk(n_casf == n0 && pend_cnt == 0, "R8 grant without req", n_casf - n0, 0);
    drv(); ref_gnt = 1'b0;
  endtask

  task automatic t_interval();
    int n0, w;
    do_reset(); wait_init();
    drv(); ref_gnt = 1'b1;
    n0 = n_casf; w = 0;
    while (n_casf < n0 + 3 && w < 1000) begin smp(); w++; end
    chk(last_casf - prev_casf == INTV, "R7 interval", last_casf - prev_casf, INTV);
    chk(!pend_ovf, "R10 no ovf when served", pend_ovf, 0);
    drv(); ref_gnt = 1'b0;
  endtask

  task automatic t_one_shot();
    int n0, w = 0;
    do_reset(); wait_init();
    while (!ref_req && w < 200) begin smp(); w++; end
    n0 = n_ras;
    drv(); ref_gnt = 1'b1;
    drv(); ref_gnt = 1'b0;
    #1;
    chk(!cas_n, "R8 cas falls after grant", cas_n, 0);
    repeat (T_CSR + T_RAS + 2) smp();
    chk(n_ras == n0 + 1 && last_len == T_RAS, "R9 completes after short grant", last_len, T_RAS);
    chk(pend_cnt == 0, "R11 pend decremented", pend_cnt, 0);
  endtask

  task automatic t_overflow();
    int n0, w = 0, nr;
    do_reset(); wait_init();
    n0 = n_casf;
    while (pend_cnt != PMAX && w < 1000) begin smp(); w++; end
    chk(pend_cnt == PMAX && !pend_ovf, "R10 saturate no ovf", pend_ovf, 0);
    chk(ref_req && n_casf == n0, "R8 req held without grant", n_casf - n0, 0);
    repeat (INTV + 2) smp();
    chk(pend_ovf && pend_cnt == PMAX, "R10 overflow flag", pend_ovf, 1);
    nr = n_ras;
    drv(); ref_gnt = 1'b1;
    w = 0;
    while (pend_cnt != 0 && w < 1000) begin smp(); w++; end
    chk(pend_cnt == 0, "R11 drained", pend_cnt, 0);
    chk(n_casf - n0 >= PMAX, "R11 drain cycles", n_casf - n0, PMAX);
    chk(pend_ovf, "R10 ovf sticky", pend_ovf, 1);
    repeat (T_RC + 2) smp();
    chk(n_ras > nr, "R11 refresh ran", n_ras - nr, PMAX);
    drv(); ref_gnt = 1'b0;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    chk(1'b0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    t_init();
    t_no_req_gnt();
    t_interval();
    t_one_shot();
    t_overflow();
    finish_run();
  end
endmodule